// File: doc/BRIEF.md
# Tagged Receive/Transmit Data FIFO Pair

This block sits behind the byte-wide data register of a synchronous serial link controller. A bus write to the register pushes a byte into an 8-entry transmit FIFO. The serial side drains that FIFO through a valid/ready handshake. On the receive side, the serial logic pushes a byte together with two tag bits, end of frame and CRC error. A bus read pops the oldest receive entry and returns only its data byte.

Each receive entry is 11 bits wide. Bits 7:0 hold the data, bit 8 holds end of frame, bit 9 holds CRC error and bit 10 holds receiver overrun. Whenever an entry is at the head of the receive FIFO, its three tags are copied into status outputs. The status outputs keep their values while the FIFO is empty. When a receive push finds the FIFO full, the byte is dropped and the overrun tag is set on the newest stored entry. That tag shows that data after this entry was lost.

Each FIFO has its own enable. While an enable is low, its FIFO is held empty and pushes into it are ignored.

Top module: `sdlc_data_fifo`

## Requirements
- R1: After reset both FIFOs are empty and neither is full, tx_valid_o is 0, and bus_rdata_o and all three status outputs are 0.
- R2: A bus write while tx_en_i is 1 pushes the byte into the transmit FIFO. tx_data_o presents the bytes in write order while tx_valid_o is 1, and each cycle with tx_valid_o and tx_ready_i both high removes one byte.
- R3: The transmit FIFO holds 8 bytes and raises tx_full_o when it holds 8. A write while it is full is ignored.
- R4: tx_en_i at 0 empties the transmit FIFO on the next clock edge and keeps it empty. Bus writes made while it is 0 are ignored.
- R5: A bus read of a non-empty receive FIFO pops the oldest entry. Its 8-bit data appears on bus_rdata_o after the next clock edge.
- R6: A bus read of an empty receive FIFO leaves bus_rdata_o at its last value and does not move the pointers. A later entry is still read back correctly.
- R7: While the receive FIFO is not empty, stat_eof_o, stat_crc_err_o and stat_ovr_o take entry bits 8, 9 and 10 of the head entry, one clock edge after that entry becomes the head.
- R8: While the receive FIFO is empty, the status outputs keep their last values.
- R9: The receive FIFO holds 8 entries and raises rx_full_o when full. A receive push while it is full is dropped and sets bit 10 (overrun) of the newest stored entry.
- R10: rx_en_i at 0 empties the receive FIFO on the next clock edge and keeps it empty. Receive pushes made while it is 0 are ignored.
- R11: A bus write and a transmit pop may occur in the same cycle. A receive push and a bus read may also occur in the same cycle. Both operations of a pair take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; 0 empties the transmit FIFO |
| rx_en_i | input | 1 | Receive enable; 0 empties the receive FIFO |
| bus_wr_i | input | 1 | Data register write strobe |
| bus_wdata_i | input | 8 | Byte to transmit |
| bus_rd_i | input | 1 | Data register read strobe |
| bus_rdata_o | output | 8 | Data byte of the last popped receive entry |
| tx_valid_o | output | 1 | Transmit FIFO has a byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Serial side takes the transmit byte |
| rx_push_i | input | 1 | Serial side delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | Byte is the last of its frame |
| rx_crc_err_i | input | 1 | CRC mismatch flagged with this byte |
| stat_eof_o | output | 1 | End-of-frame tag of the head entry |
| stat_crc_err_o | output | 1 | CRC-error tag of the head entry |
| stat_ovr_o | output | 1 | Overrun tag of the head entry |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |

## Verification
Pushes, pops and enable changes take effect at the first clock edge after the stimulus. The flags, tx_data_o and bus_rdata_o are therefore due at the next falling edge. The status outputs pass through one more register, so they are due one clock edge later than the head change. The bench drives every stimulus at a falling edge and removes it at the next falling edge, where the flags and read data are sampled. Status checks wait one further falling edge.

// File: rtl/sdlc_fifo_pkg.sv
package sdlc_fifo_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TAG_W  = 3;

  typedef struct packed {
    logic              ovr;      // bit 10
    logic              crc_err;  // bit 9
    logic              eof;      // bit 8
    logic [BYTE_W-1:0] data;     // bits 7:0
  } rx_entry_t;

  localparam int unsigned RX_W = $bits(rx_entry_t);
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] last_addr_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW:0] wr_ptr_q, rd_ptr_q;

  assign empty_o     = (wr_ptr_q == rd_ptr_q);
  assign full_o      = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                       (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign push_ok_o   = push_i && !full_o && !clear_i;
  assign pop_ok_o    = pop_i && !empty_o && !clear_i;
  assign wr_addr_o   = wr_ptr_q[AW-1:0];
  assign rd_addr_o   = rd_ptr_q[AW-1:0];
  assign last_addr_o = wr_ptr_q[AW-1:0] - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assert_full_not_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);
  assert_full_push_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i) |=> (full_o && $stable(wr_ptr_q)));
  assert_empty_pop_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(rd_ptr_q));
  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o);
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          mark_i,
  input  logic [AW-1:0] mark_addr_i,
  input  logic [W-1:0]  mark_mask_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))           mem_q[g] <= wdata_i;
      else if (mark_i && mark_addr_i == AW'(g))     mem_q[g] <= mem_q[g] | mark_mask_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_mark_sticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !(we_i && waddr_i == mark_addr_i)) |=>
      ((mem_q[$past(mark_addr_i)] & $past(mark_mask_i)) == $past(mark_mask_i)));
endmodule

// File: rtl/head_status.sv
module head_status #(
  parameter int unsigned TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          head_valid_i,
  input  logic [TW-1:0] head_tags_i,
  output logic [TW-1:0] tags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tags_o <= '0;
    else if (head_valid_i) tags_o <= head_tags_i;
  end

  assert_hold_when_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_i |=> $stable(tags_o));
endmodule

// File: rtl/sdlc_data_fifo.sv
module sdlc_data_fifo
  import sdlc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              bus_wr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_eof_i,
  input  logic              rx_crc_err_i,
  output logic              stat_eof_o,
  output logic              stat_crc_err_o,
  output logic              stat_ovr_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  output logic              rx_empty_o,
  output logic              rx_full_o
);
  // transmit side
  logic          tx_push_ok, tx_pop_ok;
  logic [AW-1:0] tx_waddr, tx_raddr, tx_last;

  fifo_ctrl #(.DEPTH(DEPTH)) i_tx_ctrl (
    .clk_i, .rst_ni,
    .clear_i    (!tx_en_i),
    .push_i     (bus_wr_i),
    .pop_i      (tx_ready_i),
    .push_ok_o  (tx_push_ok),
    .pop_ok_o   (tx_pop_ok),
    .wr_addr_o  (tx_waddr),
    .rd_addr_o  (tx_raddr),
    .last_addr_o(tx_last),
    .empty_o    (tx_empty_o),
    .full_o     (tx_full_o)
  );

  fifo_store #(.W(BYTE_W), .DEPTH(DEPTH)) i_tx_store (
    .clk_i, .rst_ni,
    .we_i       (tx_push_ok),
    .waddr_i    (tx_waddr),
    .wdata_i    (bus_wdata_i),
    .mark_i     (1'b0),
    .mark_addr_i(tx_last),
    .mark_mask_i('0),
    .raddr_i    (tx_raddr),
    .rdata_o    (tx_data_o)
  );

  assign tx_valid_o = !tx_empty_o;

  // receive side
  logic          rx_push_ok, rx_pop_ok, rx_overrun;
  logic [AW-1:0] rx_waddr, rx_raddr, rx_last;
  rx_entry_t     rx_in, rx_head, ovr_mask;

  always_comb begin
    rx_in         = '0;
    rx_in.data    = rx_data_i;
    rx_in.eof     = rx_eof_i;
    rx_in.crc_err = rx_crc_err_i;
    ovr_mask      = '0;
    ovr_mask.ovr  = 1'b1;
  end

  fifo_ctrl #(.DEPTH(DEPTH)) i_rx_ctrl (
    .clk_i, .rst_ni,
    .clear_i    (!rx_en_i),
    .push_i     (rx_push_i),
    .pop_i      (bus_rd_i),
    .push_ok_o  (rx_push_ok),
    .pop_ok_o   (rx_pop_ok),
    .wr_addr_o  (rx_waddr),
    .rd_addr_o  (rx_raddr),
    .last_addr_o(rx_last),
    .empty_o    (rx_empty_o),
    .full_o     (rx_full_o)
  );

  // dropped push tags the newest stored entry
  assign rx_overrun = rx_push_i && rx_en_i && rx_full_o;

  fifo_store #(.W(RX_W), .DEPTH(DEPTH)) i_rx_store (
    .clk_i, .rst_ni,
    .we_i       (rx_push_ok),
    .waddr_i    (rx_waddr),
    .wdata_i    (rx_in),
    .mark_i     (rx_overrun),
    .mark_addr_i(rx_last),
    .mark_mask_i(ovr_mask),
    .raddr_i    (rx_raddr),
    .rdata_o    (rx_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bus_rdata_o <= '0;
    else if (rx_pop_ok) bus_rdata_o <= rx_head.data;
  end

  head_status #(.TW(TAG_W)) i_status (
    .clk_i, .rst_ni,
    .head_valid_i(!rx_empty_o),
    .head_tags_i ({rx_head.ovr, rx_head.crc_err, rx_head.eof}),
    .tags_o      ({stat_ovr_o, stat_crc_err_o, stat_eof_o})
  );

  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && rx_empty_o) |=> $stable(bus_rdata_o));
  assert_tx_disabled_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tx_valid_o);
endmodule

// File: tb/test_sdlc_data_fifo.sv
module test_sdlc_data_fifo;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, tx_ready = 1'b0;
  logic rx_push = 1'b0, rx_eof = 1'b0, rx_crc = 1'b0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata, tx_data;
  logic tx_valid, st_eof, st_crc, st_ovr, tx_empty, tx_full, rx_empty, rx_full;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdlc_data_fifo i_sdlc_data_fifo (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .bus_wr_i(bus_wr), .bus_wdata_i(wdata), .bus_rd_i(bus_rd), .bus_rdata_o(rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_eof_i(rx_eof), .rx_crc_err_i(rx_crc),
    .stat_eof_o(st_eof), .stat_crc_err_o(st_crc), .stat_ovr_o(st_ovr),
    .tx_empty_o(tx_empty), .tx_full_o(tx_full), .rx_empty_o(rx_empty), .rx_full_o(rx_full)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] b);
    @(negedge clk); bus_wr = 1'b1; wdata = b;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read();
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rx_put(logic [7:0] d, logic e, logic c);
    @(negedge clk); rx_push = 1'b1; rx_data = d; rx_eof = e; rx_crc = c;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 full", {tx_full, rx_full}, 0); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rdata", rdata, 0); chk("R1 status", {st_ovr, st_crc, st_eof}, 0);
  endtask

  task automatic t_tx_order();
    bus_write(8'hA5); bus_write(8'h3C); bus_write(8'h7E);
    chk("R2 valid", tx_valid, 1); chk("R2 head0", tx_data, 8'hA5);
    tx_take(); chk("R2 head1", tx_data, 8'h3C);
    tx_take(); chk("R2 head2", tx_data, 8'h7E);
    tx_take(); chk("R2 drained", tx_valid, 0);
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < 9; i++) bus_write(8'(8'h10 + i));
    chk("R3 full", tx_full, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R3 order", tx_data, 8'h10 + i);
      tx_take();
    end
    chk("R3 ninth dropped", tx_empty, 1);
  endtask

  task automatic t_tx_clear();
    bus_write(8'h01); bus_write(8'h02);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); chk("R4 cleared", tx_empty, 1);
    bus_write(8'h55); chk("R4 write ignored", tx_valid, 0);
    tx_en = 1'b1;
    @(negedge clk); chk("R4 stays empty", tx_empty, 1);
  endtask

  task automatic t_rx_tags();
    rx_put(8'h11, 1'b1, 1'b0); rx_put(8'h22, 1'b0, 1'b1);
    chk("R7 head0 tags", {st_ovr, st_crc, st_eof}, 3'b001);
    bus_read(); chk("R5 data0", rdata, 8'h11);
    @(negedge clk); chk("R7 head1 tags", {st_ovr, st_crc, st_eof}, 3'b010);
    bus_read(); chk("R5 data1", rdata, 8'h22);
    @(negedge clk); @(negedge clk);
    chk("R8 hold", {st_ovr, st_crc, st_eof}, 3'b010);
    chk("R5 empty", rx_empty, 1);
  endtask

  task automatic t_rx_empty_read();
    bus_read(); chk("R6 rdata kept", rdata, 8'h22);
    chk("R6 still empty", rx_empty, 1);
    rx_put(8'h33, 1'b0, 1'b0); bus_read();
    chk("R6 next entry", rdata, 8'h33);
    chk("R6 empty after", rx_empty, 1);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 8; i++) rx_put(8'(8'h40 + i), 1'b0, 1'b0);
    chk("R9 full", rx_full, 1);
    rx_put(8'h99, 1'b1, 1'b1);
    chk("R9 still full", rx_full, 1);
    chk("R9 head tags", {st_ovr, st_crc, st_eof}, 3'b000);
    for (int i = 0; i < 8; i++) begin
      bus_read(); chk("R9 data", rdata, 8'h40 + i);
      @(negedge clk); chk("R9 ovr tag", st_ovr, (i >= 6) ? 1 : 0);
    end
    chk("R9 drained", rx_empty, 1);
  endtask

  task automatic t_rx_clear();
    rx_put(8'hC1, 1'b0, 1'b0); rx_put(8'hC2, 1'b0, 1'b0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); chk("R10 cleared", rx_empty, 1);
    rx_put(8'hC3, 1'b0, 1'b0); chk("R10 push ignored", rx_empty, 1);
    rx_en = 1'b1;
    bus_read(); chk("R10 nothing read", rdata, 8'h47);
  endtask

  task automatic t_concurrent();
    rx_put(8'h5A, 1'b1, 1'b0);
    @(negedge clk); bus_rd = 1'b1; rx_push = 1'b1; rx_data = 8'h6B; rx_eof = 1'b0; rx_crc = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rx_push = 1'b0;
    chk("R11 rx read", rdata, 8'h5A); chk("R11 rx pushed", rx_empty, 0);
    @(negedge clk); chk("R11 new head tags", {st_ovr, st_crc, st_eof}, 3'b010);
    bus_read(); chk("R11 rx second", rdata, 8'h6B);
    bus_write(8'h01); bus_write(8'h02);
    @(negedge clk); bus_wr = 1'b1; wdata = 8'h03; tx_ready = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tx_ready = 1'b0;
    chk("R11 tx head", tx_data, 8'h02);
    tx_take(); chk("R11 tx written", tx_data, 8'h03);
    tx_take(); chk("R11 tx drained", tx_empty, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_tx_full();
    t_tx_clear();
    t_rx_tags();
    t_rx_empty_read();
    t_overrun();
    t_rx_clear();
    t_concurrent();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule